// File: doc/BRIEF.md
# Ingress Notification Stamper

This block finalises a classified ingress packet descriptor just before it is written into a notification ring. It picks the target ring for each packet. The ring normally comes from the load balancer. A per-packet override bit can select the classifier's own ring index instead. The block then applies the classifier's destination decision: drop the packet, deliver the packet with its descriptor, or deliver the descriptor alone.

For each delivered packet, two fields can be filled in by hardware. The first is the running packet sequence number. The second is a seconds/nanoseconds timestamp taken at start-of-packet. Each field has its own per-packet enable. When an enable is clear, the classifier's custom contents pass through unchanged. The sequence counter advances once for every packet that is not dropped, whether or not that packet asks for the number to be inserted.

Descriptors enter and leave on valid/ready handshakes, with one output register stage. Dropped descriptors are consumed and never presented at the output. The start-of-packet timestamp arrives on a separate strobe. It is held until a later descriptor is finalised.

Top module: `notif_stamper`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and the first delivered packet with sequence insertion enabled carries sequence number 0.
- R2: The output ring index equals `in_cls_ring` when `in_ring_ovr` is 1, and `lb_ring` when it is 0.
- R3: Destination codes 0 and 3 mean drop. The descriptor is accepted, no output is produced, and the sequence counter does not change.
- R4: Destination code 1 (packet and descriptor) gives `out_with_pkt`=1. Destination code 2 (descriptor only) gives `out_with_pkt`=0. Both produce an output.
- R5: With `in_seq_en`=1, `out_seq` is the current counter value. With `in_seq_en`=0, `out_seq` equals `in_seq_custom`.
- R6: The counter increments by one for each accepted packet with destination 1 or 2, including packets with `in_seq_en`=0. It wraps modulo 2^SEQ_W.
- R7: With `in_ts_en`=1, the output timestamp is the value captured by the most recent `sop_strobe` in an earlier cycle than acceptance. A strobe in the same cycle as acceptance applies only to later packets. With `in_ts_en`=0, the custom timestamp passes through.
- R8: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is 1 and `out_ready` is 0, all outputs hold steady.
- R9: A delivered descriptor accepted on a clock edge is presented with `out_valid`=1 right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sop_strobe | input | 1 | Start-of-packet pulse; captures the timestamp |
| sop_sec | input | SEC_W | Seconds value at start-of-packet |
| sop_ns | input | NS_W | Nanoseconds value at start-of-packet |
| in_valid | input | 1 | Input descriptor valid |
| in_ready | output | 1 | Block can accept a descriptor |
| in_dest | input | 2 | Destination: 0 drop, 1 packet+descriptor, 2 descriptor only, 3 drop |
| in_ring_ovr | input | 1 | Use classifier ring instead of balancer ring |
| in_cls_ring | input | RING_W | Classifier-chosen ring |
| lb_ring | input | RING_W | Load balancer ring chosen for this descriptor |
| in_seq_en | input | 1 | Insert packet sequence number |
| in_seq_custom | input | SEQ_W | Custom contents of the sequence field |
| in_ts_en | input | 1 | Insert the start-of-packet timestamp |
| in_ts_sec_custom | input | SEC_W | Custom contents of the seconds field |
| in_ts_ns_custom | input | NS_W | Custom contents of the nanoseconds field |
| out_valid | output | 1 | Finalised descriptor valid |
| out_ready | input | 1 | Ring writer accepts the descriptor |
| out_ring | output | RING_W | Chosen notification ring |
| out_with_pkt | output | 1 | Packet data is delivered along with the descriptor |
| out_seq | output | SEQ_W | Final sequence field |
| out_ts_sec | output | SEC_W | Final seconds field |
| out_ts_ns | output | NS_W | Final nanoseconds field |

## Verification
The bench builds the block with SEQ_W set to 4 and all other parameters at their defaults. With a 16-value counter, wrap-around from 15 to 0 is reached after a short run of delivered packets. That same run checks that drops and non-inserting packets leave the count and its increments where they should be. The full-width timestamp and ring paths keep their default widths, so pass-through of wide custom values is also checked.

// File: rtl/notif_pkg.sv
package notif_pkg;
  typedef enum logic [1:0] {
    DST_DROP = 2'd0,
    DST_BOTH = 2'd1,
    DST_DESC = 2'd2,
    DST_RSVD = 2'd3
  } dest_e;

  function automatic logic dest_delivers(input logic [1:0] d);
    return (d == DST_BOTH) || (d == DST_DESC);
  endfunction

  function automatic logic dest_with_pkt(input logic [1:0] d);
    return d == DST_BOTH;
  endfunction
endpackage

// File: rtl/notif_ts_hold.sv
module notif_ts_hold #(
  parameter int SEC_W = 32,
  parameter int NS_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sop,
  input  logic [SEC_W-1:0] sop_sec,
  input  logic [NS_W-1:0]  sop_ns,
  output logic [SEC_W-1:0] held_sec,
  output logic [NS_W-1:0]  held_ns
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held_sec <= '0;
      held_ns  <= '0;
    end else if (sop) begin
      held_sec <= sop_sec;
      held_ns  <= sop_ns;
    end
  end

  AST_TS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    sop |=> (held_sec == $past(sop_sec)) && (held_ns == $past(sop_ns))); // R7
  AST_TS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sop && !$past(rst) |=> $stable(held_sec) && $stable(held_ns)); // R7
endmodule

// File: rtl/notif_seq_ctr.sv
module notif_seq_ctr #(
  parameter int SEQ_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [SEQ_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    step |=> cnt == $past(cnt) + 1'b1); // R6
  AST_SEQ_STILL: assert property (@(posedge clk) disable iff (rst)
    !step && !$past(rst) |=> $stable(cnt)); // R3
endmodule

// File: rtl/notif_out_stage.sv
module notif_out_stage #(
  parameter int RING_W = 8,
  parameter int SEQ_W  = 48,
  parameter int SEC_W  = 32,
  parameter int NS_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [RING_W-1:0] d_ring,
  input  logic              d_with_pkt,
  input  logic [SEQ_W-1:0]  d_seq,
  input  logic [SEC_W-1:0]  d_sec,
  input  logic [NS_W-1:0]   d_ns,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [RING_W-1:0] out_ring,
  output logic              out_with_pkt,
  output logic [SEQ_W-1:0]  out_seq,
  output logic [SEC_W-1:0]  out_ts_sec,
  output logic [NS_W-1:0]   out_ts_ns
);
  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (load) out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      out_ring     <= d_ring;
      out_with_pkt <= d_with_pkt;
      out_seq      <= d_seq;
      out_ts_sec   <= d_sec;
      out_ts_ns    <= d_ns;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_ring) && $stable(out_seq)
      && $stable(out_ts_sec) && $stable(out_ts_ns) && $stable(out_with_pkt)); // R8
endmodule

// File: rtl/notif_stamper.sv
module notif_stamper
  import notif_pkg::*;
#(
  parameter int RING_W = 8,
  parameter int SEQ_W  = 48,
  parameter int SEC_W  = 32,
  parameter int NS_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sop_strobe,
  input  logic [SEC_W-1:0]  sop_sec,
  input  logic [NS_W-1:0]   sop_ns,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_dest,
  input  logic              in_ring_ovr,
  input  logic [RING_W-1:0] in_cls_ring,
  input  logic [RING_W-1:0] lb_ring,
  input  logic              in_seq_en,
  input  logic [SEQ_W-1:0]  in_seq_custom,
  input  logic              in_ts_en,
  input  logic [SEC_W-1:0]  in_ts_sec_custom,
  input  logic [NS_W-1:0]   in_ts_ns_custom,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [RING_W-1:0] out_ring,
  output logic              out_with_pkt,
  output logic [SEQ_W-1:0]  out_seq,
  output logic [SEC_W-1:0]  out_ts_sec,
  output logic [NS_W-1:0]   out_ts_ns
);
  logic              accept, deliver, load;
  logic [SEQ_W-1:0]  seq_now;
  logic [SEC_W-1:0]  held_sec;
  logic [NS_W-1:0]   held_ns;
  logic [RING_W-1:0] ring_sel;
  logic [SEQ_W-1:0]  seq_sel;
  logic [SEC_W-1:0]  sec_sel;
  logic [NS_W-1:0]   ns_sel;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign deliver  = dest_delivers(in_dest);
  assign load     = accept && deliver;

  always_comb begin
    ring_sel = in_ring_ovr ? in_cls_ring : lb_ring;
    seq_sel  = in_seq_en ? seq_now : in_seq_custom;
    sec_sel  = in_ts_en ? held_sec : in_ts_sec_custom;
    ns_sel   = in_ts_en ? held_ns : in_ts_ns_custom;
  end

  notif_ts_hold #(.SEC_W(SEC_W), .NS_W(NS_W)) u_ts (
    .clk(clk), .rst(rst), .sop(sop_strobe), .sop_sec(sop_sec), .sop_ns(sop_ns),
    .held_sec(held_sec), .held_ns(held_ns)
  );

  notif_seq_ctr #(.SEQ_W(SEQ_W)) u_seq (
    .clk(clk), .rst(rst), .step(load), .cnt(seq_now)
  );

  notif_out_stage #(.RING_W(RING_W), .SEQ_W(SEQ_W), .SEC_W(SEC_W), .NS_W(NS_W)) u_out (
    .clk(clk), .rst(rst), .load(load),
    .d_ring(ring_sel), .d_with_pkt(dest_with_pkt(in_dest)), .d_seq(seq_sel),
    .d_sec(sec_sel), .d_ns(ns_sel), .out_ready(out_ready),
    .out_valid(out_valid), .out_ring(out_ring), .out_with_pkt(out_with_pkt),
    .out_seq(out_seq), .out_ts_sec(out_ts_sec), .out_ts_ns(out_ts_ns)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> !out_valid); // R1
  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (rst)
    accept && !deliver |=> !out_valid); // R3
  AST_LOAD_NEXT: assert property (@(posedge clk) disable iff (rst)
    load |=> out_valid); // R9
  AST_RING_OVR: assert property (@(posedge clk) disable iff (rst)
    load && in_ring_ovr |=> out_ring == $past(in_cls_ring)); // R2
  AST_RING_LB: assert property (@(posedge clk) disable iff (rst)
    load && !in_ring_ovr |=> out_ring == $past(lb_ring)); // R2
endmodule

// File: tb/test_notif_stamper.sv
module test_notif_stamper;
  localparam int CLK_PERIOD = 10;
  localparam int RING_W = 8;
  localparam int SEQ_W  = 4;
  localparam int SEC_W  = 32;
  localparam int NS_W   = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sop_strobe = 1'b0;
  logic [SEC_W-1:0]  sop_sec = '0;
  logic [NS_W-1:0]   sop_ns = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [1:0]        in_dest = '0;
  logic              in_ring_ovr = 1'b0;
  logic [RING_W-1:0] in_cls_ring = '0;
  logic [RING_W-1:0] lb_ring = '0;
  logic              in_seq_en = 1'b0;
  logic [SEQ_W-1:0]  in_seq_custom = '0;
  logic              in_ts_en = 1'b0;
  logic [SEC_W-1:0]  in_ts_sec_custom = '0;
  logic [NS_W-1:0]   in_ts_ns_custom = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [RING_W-1:0] out_ring;
  logic              out_with_pkt;
  logic [SEQ_W-1:0]  out_seq;
  logic [SEC_W-1:0]  out_ts_sec;
  logic [NS_W-1:0]   out_ts_ns;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [SEQ_W-1:0] exp_seq = '0;
  logic [SEC_W-1:0] exp_sec = '0;
  logic [NS_W-1:0]  exp_ns = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  notif_stamper #(.RING_W(RING_W), .SEQ_W(SEQ_W), .SEC_W(SEC_W), .NS_W(NS_W)) i_notif_stamper (
    .clk(clk), .rst(rst), .sop_strobe(sop_strobe), .sop_sec(sop_sec), .sop_ns(sop_ns),
    .in_valid(in_valid), .in_ready(in_ready), .in_dest(in_dest), .in_ring_ovr(in_ring_ovr),
    .in_cls_ring(in_cls_ring), .lb_ring(lb_ring), .in_seq_en(in_seq_en),
    .in_seq_custom(in_seq_custom), .in_ts_en(in_ts_en), .in_ts_sec_custom(in_ts_sec_custom),
    .in_ts_ns_custom(in_ts_ns_custom), .out_valid(out_valid), .out_ready(out_ready),
    .out_ring(out_ring), .out_with_pkt(out_with_pkt), .out_seq(out_seq),
    .out_ts_sec(out_ts_sec), .out_ts_ns(out_ts_ns)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Presents one descriptor at a negedge; returns at the next negedge.
  task automatic send(input logic [1:0] dest, input logic ovr, input logic [7:0] cls,
                      input logic [7:0] lb, input logic seq_en, input logic [3:0] seq_c,
                      input logic ts_en, input logic [31:0] sec_c, input logic [31:0] ns_c);
    in_valid = 1'b1; in_dest = dest; in_ring_ovr = ovr; in_cls_ring = cls; lb_ring = lb;
    in_seq_en = seq_en; in_seq_custom = seq_c; in_ts_en = ts_en;
    in_ts_sec_custom = sec_c; in_ts_ns_custom = ns_c;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    sop_strobe = 1'b0;
  endtask

  task automatic pulse_sop(input logic [31:0] s, input logic [31:0] n);
    sop_strobe = 1'b1; sop_sec = s; sop_ns = n;
    @(posedge clk);
    @(negedge clk);
    sop_strobe = 1'b0;
    exp_sec = s; exp_ns = n;
  endtask

  task automatic t_reset;
    check("R1 out_valid", {63'd0, out_valid}, 64'd0);
    check("R1 in_ready", {63'd0, in_ready}, 64'd1);
    send(2'd1, 1'b0, 8'h00, 8'h11, 1'b1, 4'h9, 1'b0, 32'h0, 32'h0);
    check("R1 first seq", {60'd0, out_seq}, 64'd0);
    check("R9 valid next", {63'd0, out_valid}, 64'd1);
    exp_seq = exp_seq + 1'b1;
  endtask

  task automatic t_ring;
    send(2'd1, 1'b0, 8'hAA, 8'h35, 1'b0, 4'h0, 1'b0, 32'h0, 32'h0);
    check("R2 balancer ring", {56'd0, out_ring}, 64'h35);
    exp_seq = exp_seq + 1'b1;
    send(2'd2, 1'b1, 8'hC7, 8'h35, 1'b0, 4'h0, 1'b0, 32'h0, 32'h0);
    check("R2 override ring", {56'd0, out_ring}, 64'hC7);
    exp_seq = exp_seq + 1'b1;
  endtask

  task automatic t_dest;
    send(2'd1, 1'b0, 8'h0, 8'h1, 1'b0, 4'h0, 1'b0, 32'h0, 32'h0);
    check("R4 both with_pkt", {63'd0, out_with_pkt}, 64'd1);
    exp_seq = exp_seq + 1'b1;
    send(2'd2, 1'b0, 8'h0, 8'h1, 1'b0, 4'h0, 1'b0, 32'h0, 32'h0);
    check("R4 desc only with_pkt", {63'd0, out_with_pkt}, 64'd0);
    check("R4 desc only valid", {63'd0, out_valid}, 64'd1);
    exp_seq = exp_seq + 1'b1;
    send(2'd0, 1'b0, 8'h0, 8'h1, 1'b1, 4'h0, 1'b0, 32'h0, 32'h0);
    check("R3 drop code0 silent", {63'd0, out_valid}, 64'd0);
    send(2'd3, 1'b0, 8'h0, 8'h1, 1'b1, 4'h0, 1'b0, 32'h0, 32'h0);
    check("R3 drop code3 silent", {63'd0, out_valid}, 64'd0);
    send(2'd1, 1'b0, 8'h0, 8'h1, 1'b1, 4'h0, 1'b0, 32'h0, 32'h0);
    check("R3 counter unchanged by drops", {60'd0, out_seq}, {60'd0, exp_seq});
    exp_seq = exp_seq + 1'b1;
  endtask

  task automatic t_seq;
    send(2'd2, 1'b0, 8'h0, 8'h1, 1'b0, 4'hD, 1'b0, 32'h0, 32'h0);
    check("R5 custom seq", {60'd0, out_seq}, 64'hD);
    exp_seq = exp_seq + 1'b1;
    send(2'd1, 1'b0, 8'h0, 8'h1, 1'b1, 4'h0, 1'b0, 32'h0, 32'h0);
    check("R6 custom packet advanced count", {60'd0, out_seq}, {60'd0, exp_seq});
    exp_seq = exp_seq + 1'b1;
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 20; i++) begin
      send(2'd1, 1'b0, 8'h0, 8'h1, 1'b1, 4'h0, 1'b0, 32'h0, 32'h0);
      check("R6 seq wrap run", {60'd0, out_seq}, {60'd0, exp_seq});
      exp_seq = exp_seq + 1'b1;
    end
  endtask

  task automatic t_ts;
    pulse_sop(32'h1234_5678, 32'h0ABC_DEF0);
    send(2'd1, 1'b0, 8'h0, 8'h1, 1'b0, 4'h0, 1'b1, 32'hFFFF_0000, 32'h0000_FFFF);
    check("R7 ts sec inserted", {32'd0, out_ts_sec}, {32'd0, exp_sec});
    check("R7 ts ns inserted", {32'd0, out_ts_ns}, {32'd0, exp_ns});
    exp_seq = exp_seq + 1'b1;
    send(2'd1, 1'b0, 8'h0, 8'h1, 1'b0, 4'h0, 1'b0, 32'hDEAD_BEEF, 32'hCAFE_F00D);
    check("R7 custom sec", {32'd0, out_ts_sec}, 64'hDEAD_BEEF);
    check("R7 custom ns", {32'd0, out_ts_ns}, 64'hCAFE_F00D);
    exp_seq = exp_seq + 1'b1;
    sop_strobe = 1'b1; sop_sec = 32'h7777_0001; sop_ns = 32'h7777_0002;
    send(2'd2, 1'b0, 8'h0, 8'h1, 1'b0, 4'h0, 1'b1, 32'h0, 32'h0);
    check("R7 same-cycle sop uses older sec", {32'd0, out_ts_sec}, {32'd0, exp_sec});
    exp_seq = exp_seq + 1'b1;
    exp_sec = 32'h7777_0001; exp_ns = 32'h7777_0002;
    send(2'd2, 1'b0, 8'h0, 8'h1, 1'b0, 4'h0, 1'b1, 32'h0, 32'h0);
    check("R7 later packet sees new ns", {32'd0, out_ts_ns}, {32'd0, exp_ns});
    exp_seq = exp_seq + 1'b1;
  endtask

  task automatic t_backpressure;
    @(negedge clk); // drain
    out_ready = 1'b0;
    send(2'd1, 1'b0, 8'h0, 8'h5A, 1'b1, 4'h0, 1'b0, 32'h0, 32'h0);
    check("R8 first seq loaded", {60'd0, out_seq}, {60'd0, exp_seq});
    exp_seq = exp_seq + 1'b1;
    in_valid = 1'b1; in_dest = 2'd1; in_ring_ovr = 1'b0; lb_ring = 8'h66; in_seq_en = 1'b1;
    #1;
    check("R8 in_ready low when stalled", {63'd0, in_ready}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    check("R8 ring held", {56'd0, out_ring}, 64'h5A);
    check("R8 valid held", {63'd0, out_valid}, 64'd1);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 next ring after release", {56'd0, out_ring}, 64'h66);
    check("R8 next seq after release", {60'd0, out_seq}, {60'd0, exp_seq});
    exp_seq = exp_seq + 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ring();
    t_dest();
    t_seq();
    t_wrap();
    t_ts();
    t_backpressure();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule